// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Protector

This block guards 8-bit memory words with an extended Hamming code. On the write side, an encoder turns each data byte into a 13-bit word for storage. That word holds four check bits at the power-of-two positions, the eight data bits in the positions between them, and one overall even-parity bit. On the read side, a checker takes a fetched 13-bit word and recomputes the check bits from its data positions. It XORs them with the stored check bits to form a syndrome. When the syndrome is nonzero, its value is the position of the flipped bit.

The overall parity bit tells a lone error apart from a pair of errors. With it, the checker fixes any single flipped bit and reports, without miscorrecting, any two flipped bits. Each path has its own valid strobe and is registered with one cycle of latency. A new word can enter either path on every clock.

Top module: `secded_codec`

## Requirements
- R1: Stored word bit p (1 to 12) holds Hamming position p. Check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 (bit 0 is the least significant) sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: The check bit at position 2^k is the XOR of the data-carrying positions whose number has bit k set. Bit 0 of the stored word makes the count of ones over all 13 bits even.
- R3: `enc_valid_o` follows `enc_valid_i` one clock later, and `enc_code_o` shows the code of the byte presented in that earlier cycle.
- R4: A fetched word with no flipped bit gives back its data, a zero syndrome, and both flags low.
- R5: A single flipped data position is corrected on `dec_data_o`. `dec_syndrome_o` equals that position, `dec_single_o` is 1 and `dec_double_o` is 0.
- R6: A single flipped check bit (position 1, 2, 4 or 8) leaves the data unchanged. The syndrome equals that position and `dec_single_o` is 1.
- R7: A flipped overall parity bit (bit 0) alone gives a zero syndrome, intact data and `dec_single_o` = 1.
- R8: Two flipped bits give `dec_double_o` = 1 and `dec_single_o` = 0. The data output is the fetched data bits with no correction applied, and the syndrome is the XOR of the two positions (bit 0 counts as position 0).
- R9: A nonzero syndrome that names no existing position (13 to 15) is reported as a double error, and nothing is corrected.
- R10: Byte 0x39 encodes to 0x69F. Flipping data bit 2 (position 6) of that word yields syndrome 4'b0110, and the data is corrected back to 0x39.
- R11: The checker's outputs appear one clock after `dec_valid_i`. While a path's valid input is low, its registered outputs hold and its data input is ignored.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_i | input | 1 | A byte to encode is present |
| enc_data_i | input | 8 | Byte to encode |
| enc_valid_o | output | 1 | Encoded word is valid |
| enc_code_o | output | 13 | Encoded word for storage |
| dec_valid_i | input | 1 | A fetched word is present |
| dec_code_i | input | 13 | Fetched word to check |
| dec_valid_o | output | 1 | Check result is valid |
| dec_data_o | output | 8 | Corrected (or raw, on double error) data |
| dec_syndrome_o | output | 4 | Syndrome value |
| dec_single_o | output | 1 | Single error seen (corrected or harmless) |
| dec_double_o | output | 1 | Uncorrectable error seen |

## Verification
The bench walks a single flip through every one of the 13 bit positions and checks each flip class on its own. A checker that decided single versus double from the syndrome alone would miscorrect pairs, and would also fail to flag a lone flip of the parity bit. Pairs that include bit 0, and triples whose syndrome lands on 13 to 15, catch a design that flips a nonexistent bit or reports such words as single errors. Flips on the check positions catch a design that corrupts data when the syndrome points at a check bit. The worked byte 0x39 pins down the bit order, and idle cycles with a changing input catch outputs that do not hold.

// File: rtl/secded_pkg.sv
// Package: shared helpers for the extended Hamming layout.
// Assumes positions are numbered from 1. Position 0 is the overall parity bit.
package secded_pkg;

    // True when p is a nonzero power of two (a check-bit position).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Smallest check-bit count K with 2^K - 1 >= m + K.
    function automatic int chk_bits_for(input int m);
        int k;
        k = 1;
        for (int t = 0; t < 16; t++) begin
            if (((1 << k) - 1) < (m + k)) k++;
        end
        return k;
    endfunction

    // Position of the n-th data bit (n from 1): the n-th position that is not a power of two.
    function automatic int data_pos(input int n);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < 256; p++) begin
            if (!is_pow2(p) && (res == 0)) begin
                cnt++;
                if (cnt == n) res = p;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
// Encoder: places data bits at the non-power-of-two positions, computes the
// positional check bits and the overall even parity, and registers the word.
// Assumes DATA_W is small enough that all positions fit below 256.
module secded_encoder #(
    parameter int DATA_W = 8
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              valid_i,
    input  logic [DATA_W-1:0]                                 data_i,
    output logic                                              valid_o,
    output logic [DATA_W+secded_pkg::chk_bits_for(DATA_W):0]  code_o
);
    import secded_pkg::*;

    localparam int CHK_W  = chk_bits_for(DATA_W);
    localparam int CODE_W = DATA_W + CHK_W + 1;

    logic [CODE_W-1:0] word;

    // Build the full protected word from the incoming data.
    always_comb begin
        logic acc;
        word = '0;
        for (int i = 0; i < DATA_W; i++) word[data_pos(i + 1)] = data_i[i];
        for (int k = 0; k < CHK_W; k++) begin
            acc = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (!is_pow2(p) && p[k]) acc = acc ^ word[p];
            end
            word[1 << k] = acc;
        end
        word[0] = ^word[CODE_W-1:1];
    end

    // Register the encoded word on a valid strobe and pipe the strobe along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) code_o <= word;
        end
    end

endmodule

// File: rtl/secded_syndrome.sv
// Syndrome unit: recomputes each check bit from the fetched data positions,
// XORs it with the stored check bit, and reports the overall parity of the word.
// Purely combinational.
module secded_syndrome #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_W = 13
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syn_o,
    output logic              perr_o
);
    import secded_pkg::*;

    // Stored versus recomputed check bits, one syndrome bit per check bit.
    always_comb begin
        logic acc;
        syn_o = '0;
        for (int k = 0; k < CHK_W; k++) begin
            acc = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (!is_pow2(p) && p[k]) acc = acc ^ code_i[p];
            end
            syn_o[k] = acc ^ code_i[1 << k];
        end
        perr_o = ^code_i;
    end

endmodule

// File: rtl/secded_corrector.sv
// Corrector: classifies the error from syndrome and overall parity, flips the
// named bit for a single error, and pulls the data bits out of the word.
// A syndrome above the last position is treated as uncorrectable.
module secded_corrector #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_W = 13
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              perr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    import secded_pkg::*;

    logic [CODE_W-1:0] fixed;

    // Decide the error class and repair the word where that is safe.
    always_comb begin
        fixed    = code_i;
        single_o = 1'b0;
        double_o = 1'b0;
        data_o   = '0;
        if (syn_i == '0) begin
            single_o = perr_i;
        end else if (perr_i && (int'(syn_i) < CODE_W)) begin
            single_o     = 1'b1;
            fixed[syn_i] = ~code_i[syn_i];
        end else begin
            double_o = 1'b1;
        end
        for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[data_pos(i + 1)];
    end

endmodule

// File: rtl/secded_codec.sv
// Top: an encode path and a check path, each registered with one cycle of
// latency and its own valid strobe. Outputs hold while the valid input is low.
module secded_codec #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = secded_pkg::chk_bits_for(DATA_W),
    parameter int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_syndrome_o,
    output logic              dec_single_o,
    output logic              dec_double_o
);

    logic [CHK_W-1:0]  syn;
    logic              perr;
    logic [DATA_W-1:0] fix_data;
    logic              fix_single;
    logic              fix_double;

    secded_encoder #(.DATA_W(DATA_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    secded_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_syn (
        .code_i (dec_code_i),
        .syn_o  (syn),
        .perr_o (perr)
    );

    secded_corrector #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_fix (
        .code_i   (dec_code_i),
        .syn_i    (syn),
        .perr_i   (perr),
        .data_o   (fix_data),
        .single_o (fix_single),
        .double_o (fix_double)
    );

    // Register the check result on a valid strobe and pipe the strobe along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o    <= 1'b0;
            dec_data_o     <= '0;
            dec_syndrome_o <= '0;
            dec_single_o   <= 1'b0;
            dec_double_o   <= 1'b0;
        end else begin
            dec_valid_o <= dec_valid_i;
            if (dec_valid_i) begin
                dec_data_o     <= fix_data;
                dec_syndrome_o <= syn;
                dec_single_o   <= fix_single;
                dec_double_o   <= fix_double;
            end
        end
    end

endmodule

// File: rtl/secded_codec_sva.sv
// Checker: port-level properties of secded_codec, attached by bind below.
module secded_codec_sva #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CODE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic              enc_valid_o,
    input logic [CODE_W-1:0] enc_code_o,
    input logic              dec_valid_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [CHK_W-1:0]  dec_syndrome_o,
    input logic              dec_single_o,
    input logic              dec_double_o
);

    assert_enc_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);

    assert_enc_idle_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> !enc_valid_o);

    assert_enc_even_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> ((^enc_code_o) == 1'b0));

    assert_dec_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    assert_dec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_syndrome_o)
                          && $stable(dec_single_o) && $stable(dec_double_o)));

    assert_enc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> $stable(enc_code_o));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_single_o && dec_double_o));

    assert_double_nonzero_syn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_double_o |-> (dec_syndrome_o != '0));

    assert_clean_no_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_syndrome_o != '0) |-> (dec_single_o || dec_double_o));

endmodule

bind secded_codec secded_codec_sva #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_valid_i    (enc_valid_i),
    .enc_valid_o    (enc_valid_o),
    .enc_code_o     (enc_code_o),
    .dec_valid_i    (dec_valid_i),
    .dec_valid_o    (dec_valid_o),
    .dec_data_o     (dec_data_o),
    .dec_syndrome_o (dec_syndrome_o),
    .dec_single_o   (dec_single_o),
    .dec_double_o   (dec_double_o)
);

// File: tb/sim_secded_codec.sv
// Scoreboard bench: driver tasks queue expected results, a monitor compares them.
module sim_secded_codec;

    localparam real HALF = 2.5;   // 200 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic        enc_valid_o;
    logic [12:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [12:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [7:0]  dec_data_o;
    logic [3:0]  dec_syndrome_o;
    logic        dec_single_o;
    logic        dec_double_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [12:0] code;
        string       tag;
    } enc_exp_t;

    typedef struct {
        logic [7:0] data;
        logic [3:0] syn;
        logic       single;
        logic       double;
        string      tag;
    } dec_exp_t;

    enc_exp_t eq[$];
    dec_exp_t dq[$];
    enc_exp_t last_enc;
    dec_exp_t last_dec;

    localparam int POS [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

    always #(HALF) clk = ~clk;

    secded_codec u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .enc_valid_i    (enc_valid_i),
        .enc_data_i     (enc_data_i),
        .enc_valid_o    (enc_valid_o),
        .enc_code_o     (enc_code_o),
        .dec_valid_i    (dec_valid_i),
        .dec_code_i     (dec_code_i),
        .dec_valid_o    (dec_valid_o),
        .dec_data_o     (dec_data_o),
        .dec_syndrome_o (dec_syndrome_o),
        .dec_single_o   (dec_single_o),
        .dec_double_o   (dec_double_o)
    );

    // Reference encoding built from the position table of R1 and R2.
    function automatic logic [12:0] ref_enc(input logic [7:0] d);
        logic [12:0] w;
        w = '0;
        for (int i = 0; i < 8; i++) w[POS[i]] = d[i];
        for (int k = 0; k < 4; k++) begin
            logic c;
            c = 1'b0;
            for (int i = 0; i < 8; i++) if (POS[i][k]) c = c ^ d[i];
            w[1 << k] = c;
        end
        w[0] = ^w[12:1];
        return w;
    endfunction

    function automatic logic [7:0] ref_raw(input logic [12:0] w);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) d[i] = w[POS[i]];
        return d;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
    endtask

    task automatic drive_enc(input logic [7:0] d, input logic [12:0] exp, input string tag);
        enc_exp_t e;
        @(negedge clk);
        enc_valid_i = 1'b1;
        dec_valid_i = 1'b0;
        enc_data_i  = d;
        e.code = exp;
        e.tag  = tag;
        eq.push_back(e);
        last_enc = e;
    endtask

    task automatic drive_dec(input logic [12:0] w, input logic [7:0] d, input logic [3:0] s,
                             input logic sg, input logic db, input string tag);
        dec_exp_t e;
        @(negedge clk);
        dec_valid_i = 1'b1;
        enc_valid_i = 1'b0;
        dec_code_i  = w;
        e.data = d; e.syn = s; e.single = sg; e.double = db; e.tag = tag;
        dq.push_back(e);
        last_dec = e;
    endtask

    // Flip the bits in mask on a good word and queue the outcome the rules demand.
    task automatic dec_case(input logic [7:0] d, input logic [12:0] mask, input string tag);
        logic [12:0] w;
        logic [3:0]  s;
        int n;
        w = ref_enc(d) ^ mask;
        n = $countones(mask);
        s = '0;
        for (int p = 1; p < 13; p++) if (mask[p]) s = s ^ 4'(p);
        if (n == 0)      drive_dec(w, d, 4'd0, 1'b0, 1'b0, tag);
        else if (n == 1) drive_dec(w, d, s, 1'b1, 1'b0, tag);
        else             drive_dec(w, ref_raw(w), s, 1'b0, 1'b1, tag);
    endtask

    // Monitor: compare each valid result against the head of its queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (enc_valid_o) begin
                    if (eq.size() == 0) check(1'b0, "R3", "unexpected enc valid", 1, 0);
                    else begin
                        enc_exp_t e;
                        e = eq.pop_front();
                        check(enc_code_o == e.code, e.tag, "enc_code_o", 32'(enc_code_o), 32'(e.code));
                    end
                end
                if (dec_valid_o) begin
                    if (dq.size() == 0) check(1'b0, "R11", "unexpected dec valid", 1, 0);
                    else begin
                        dec_exp_t e;
                        e = dq.pop_front();
                        check(dec_data_o == e.data, e.tag, "dec_data_o", 32'(dec_data_o), 32'(e.data));
                        check(dec_syndrome_o == e.syn, e.tag, "dec_syndrome_o", 32'(dec_syndrome_o), 32'(e.syn));
                        check({dec_single_o, dec_double_o} == {e.single, e.double}, e.tag,
                              "single,double", 32'({dec_single_o, dec_double_o}), 32'({e.single, e.double}));
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R12: outputs zero while reset is held.
        repeat (3) @(posedge clk);
        #1;
        check({enc_valid_o, enc_code_o, dec_valid_o, dec_data_o, dec_syndrome_o,
               dec_single_o, dec_double_o} == '0, "R12", "outputs in reset",
              32'({enc_valid_o, enc_code_o, dec_valid_o, dec_data_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 and R10: single encode, latency observed directly.
        drive_enc(8'h39, 13'h69F, "R10");
        @(posedge clk);
        #1;
        check(enc_valid_o == 1'b1, "R3", "enc_valid_o one cycle later", 32'(enc_valid_o), 1);
        idle();
        @(posedge clk);
        #1;
        check(enc_valid_o == 1'b0, "R3", "enc_valid_o after idle", 32'(enc_valid_o), 0);

        // R1 / R2: encode a burst of patterns back to back.
        drive_enc(8'h00, ref_enc(8'h00), "R2");
        drive_enc(8'hFF, ref_enc(8'hFF), "R2");
        drive_enc(8'hA5, ref_enc(8'hA5), "R1");
        drive_enc(8'h5A, ref_enc(8'h5A), "R1");
        for (int i = 0; i < 8; i++) drive_enc(8'(1 << i), ref_enc(8'(1 << i)), "R1");
        idle();

        // R4: clean words.
        dec_case(8'h00, 13'h0, "R4");
        dec_case(8'hFF, 13'h0, "R4");
        dec_case(8'h39, 13'h0, "R4");
        dec_case(8'h96, 13'h0, "R4");

        // R5: every data position flipped singly.
        for (int i = 0; i < 8; i++) dec_case(8'h39, 13'(1 << POS[i]), "R5");
        for (int i = 0; i < 8; i++) dec_case(8'hC6, 13'(1 << POS[i]), "R5");

        // R10: the worked example with a hand-written expectation.
        drive_dec(13'h69F ^ 13'h040, 8'h39, 4'b0110, 1'b1, 1'b0, "R10");

        // R6: check-bit positions.
        for (int k = 0; k < 4; k++) dec_case(8'h5A, 13'(1 << (1 << k)), "R6");

        // R7: overall parity bit alone.
        dec_case(8'h5A, 13'h001, "R7");
        dec_case(8'h00, 13'h001, "R7");

        // R8: pairs of flips, including ones involving bit 0 and check bits.
        dec_case(8'hA5, (13'h1 << 3) | (13'h1 << 5), "R8");
        dec_case(8'hA5, (13'h1 << 1) | (13'h1 << 12), "R8");
        dec_case(8'hA5, 13'h001 | (13'h1 << 7), "R8");
        dec_case(8'hA5, (13'h1 << 6) | (13'h1 << 10), "R8");
        dec_case(8'h3C, (13'h1 << 2) | (13'h1 << 4), "R8");

        // R9: odd flips whose syndrome names a nonexistent position.
        dec_case(8'h81, 13'h001 | (13'h1 << 5) | (13'h1 << 8), "R9");
        dec_case(8'h81, 13'h001 | (13'h1 << 7) | (13'h1 << 8), "R9");
        dec_case(8'h81, 13'h001 | (13'h1 << 6) | (13'h1 << 8), "R9");

        // R11: idle with a changing data input; outputs must hold.
        idle();
        dec_code_i = 13'h1ABC;
        enc_data_i = 8'h77;
        repeat (3) begin
            @(negedge clk);
            dec_code_i = ~dec_code_i;
            enc_data_i = ~enc_data_i;
        end
        @(posedge clk);
        #1;
        check(dec_valid_o == 1'b0, "R11", "dec_valid_o idle", 32'(dec_valid_o), 0);
        check(dec_data_o == last_dec.data, "R11", "dec_data_o held", 32'(dec_data_o), 32'(last_dec.data));
        check(dec_syndrome_o == last_dec.syn, "R11", "dec_syndrome_o held",
              32'(dec_syndrome_o), 32'(last_dec.syn));
        check(enc_code_o == last_enc.code, "R11", "enc_code_o held", 32'(enc_code_o), 32'(last_enc.code));

        repeat (3) @(posedge clk);
        #1;
        check(eq.size() == 0, "R3", "encode results missing", 32'(eq.size()), 0);
        check(dq.size() == 0, "R11", "check results missing", 32'(dq.size()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule